// File: doc/BRIEF.md
# Beam-Synchronous Multichannel Time Digitizer

This block measures when a discriminator edge arrives on each of its channels, inside each beam crossing. A fast clock locked to the beam clock drives one fine-time counter that all channels share. A single-cycle crossing marker restarts the counter in the first fast cycle of every crossing. Each channel passes its discriminator level through a synchronizer and then detects rising edges on the fast clock. On the first rising edge in a crossing, the channel freezes the counter value as its time stamp.

When the next crossing marker arrives, the block closes the crossing that just ended. It moves every channel's hit flag and time stamp into output registers and raises a one-cycle valid strobe. The hit flags form a parallel trigger word with one bit per channel. The time stamps are packed into one vector, and a separate set of per-channel valid bits goes with them. Downstream trigger and readout logic take these outputs in the cycle the strobe is high. The outputs stay unchanged until the next crossing closes.

Top module: `beam_tdc`

## Requirements
- R1: While reset is active, and until the first crossing closes, data_valid, trig_word, tdc_valid and tdc_vals are all zero.
- R2: The fine bin is 0 in the cycle where cross_mark is high. It then rises by one in each following fast cycle.
- R3: The fine bin stops at 2^BIN_W-1 (63 by default) when a crossing lasts longer than 2^BIN_W fast cycles. It stays there until the next cross_mark.
- R4: The synchronizer has two stages. A rising level on disc_in[i], first sampled in fast cycle c, counts as an edge in cycle c+2. The channel's time stamp is the fine bin of cycle c+2.
- R5: A channel latches only its first edge in a crossing. Later edges in the same crossing leave its time stamp unchanged.
- R6: In the cycle after a cross_mark cycle, data_valid is high for exactly one cycle and the outputs describe the crossing that just ended. In every other cycle, data_valid is low and the outputs hold their values.
- R7: trig_word[i] is 1 exactly when channel i had a hit in the completed crossing, and tdc_valid[i] equals trig_word[i]. A channel with no hit reports time 0.
- R8: An edge detected in the cross_mark cycle belongs to the new crossing and gets time 0. It does not appear in the crossing being closed.
- R9: The time of channel i is at tdc_vals[BIN_W*i +: BIN_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast digitizing clock, an integer multiple of the beam clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cross_mark | input | 1 | High for the first fast cycle of each beam crossing |
| disc_in | input | N_CH | Discriminator levels, one per channel, asynchronous |
| data_valid | output | 1 | One-cycle strobe that marks fresh crossing results |
| trig_word | output | N_CH | Hit bit per channel for the completed crossing |
| tdc_valid | output | N_CH | Time-valid bit per channel |
| tdc_vals | output | N_CH*BIN_W | Packed per-channel time stamps |

## Verification
The fine counter and the capture flags are not visible at the ports. Faults in them show up in the time stamps and trigger bits one cycle after the crossing closes.

- **Counter faults:** a counter that slips or wraps gives time stamps that are off by a constant, or that fall back near zero on long crossings.
- **Edge or ordering faults:** a lost first-edge lock, or a wrong credit at the boundary, changes one channel's value or moves its hit into the neighbouring crossing. Both show at the next valid strobe.
- **Synchronizer faults:** a wrong synchronizer depth moves every time stamp by the same offset.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
   localparam int DEF_CHANNELS = 32;
   localparam int DEF_BIN_W    = 6;
   localparam int DEF_SYNC     = 2;

   function automatic logic rising(input logic prev, input logic cur);
      return cur & ~prev;
   endfunction
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync
   import tdc_pkg::*;
#(
   parameter int STAGES = DEF_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = rising(chain[STAGES], chain[STAGES-1]);
endmodule

// File: rtl/tdc_bin_counter.sv
module tdc_bin_counter #(
   parameter int BIN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark,
   output logic [BIN_W-1:0] cur_bin
);
   localparam logic [BIN_W-1:0] TOP = '1;
   localparam logic [BIN_W-1:0] ONE = BIN_W'(1);

   logic [BIN_W-1:0] bin_q;

   assign cur_bin = mark ? '0 : bin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bin_q <= '0;
      else if (mark)        bin_q <= ONE;
      else if (bin_q != TOP) bin_q <= bin_q + ONE;
   end
endmodule

// File: rtl/tdc_capture.sv
module tdc_capture #(
   parameter int BIN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark,
   input  logic             rise,
   input  logic [BIN_W-1:0] cur_bin,
   output logic             hit_o,
   output logic [BIN_W-1:0] val_o
);
   logic             hit_q;
   logic [BIN_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         val_q <= '0;
         hit_o <= 1'b0;
         val_o <= '0;
      end else if (mark) begin
         hit_o <= hit_q;
         val_o <= val_q;
         hit_q <= rise;
         val_q <= rise ? cur_bin : '0;
      end else if (rise && !hit_q) begin
         hit_q <= 1'b1;
         val_q <= cur_bin;
      end
   end
endmodule

// File: rtl/beam_tdc.sv
module beam_tdc
   import tdc_pkg::*;
#(
   parameter int N_CH        = DEF_CHANNELS,
   parameter int BIN_W       = DEF_BIN_W,
   parameter int SYNC_STAGES = DEF_SYNC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cross_mark,
   input  logic [N_CH-1:0]       disc_in,
   output logic                  data_valid,
   output logic [N_CH-1:0]       trig_word,
   output logic [N_CH-1:0]       tdc_valid,
   output logic [N_CH*BIN_W-1:0] tdc_vals
);
   localparam int VALS_W = N_CH * BIN_W;

   generate
      if (N_CH < 1)       $error("beam_tdc: N_CH must be at least 1");
      if (BIN_W < 1)      $error("beam_tdc: BIN_W must be at least 1");
      if (SYNC_STAGES < 2) $error("beam_tdc: SYNC_STAGES must be at least 2");
      if (VALS_W < 1)     $error("beam_tdc: empty time vector");
   endgenerate

   logic [BIN_W-1:0] cur_bin;
   logic [N_CH-1:0]  rise;
   logic [N_CH-1:0]  hit;

   tdc_bin_counter #(.BIN_W(BIN_W)) i_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .mark    (cross_mark),
      .cur_bin (cur_bin)
   );

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
      tdc_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (disc_in[ch]),
         .rise  (rise[ch])
      );
      tdc_capture #(.BIN_W(BIN_W)) i_cap (
         .clk     (clk),
         .rst_n   (rst_n),
         .mark    (cross_mark),
         .rise    (rise[ch]),
         .cur_bin (cur_bin),
         .hit_o   (hit[ch]),
         .val_o   (tdc_vals[BIN_W*ch +: BIN_W])
      );
   end

   assign trig_word = hit;
   assign tdc_valid = hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_valid <= 1'b0;
      else        data_valid <= cross_mark;
   end
endmodule

// File: rtl/beam_tdc_chk.sv
module beam_tdc_chk #(
   parameter int N_CH  = 32,
   parameter int BIN_W = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cross_mark,
   input logic                  data_valid,
   input logic [N_CH-1:0]       trig_word,
   input logic [N_CH-1:0]       tdc_valid,
   input logic [N_CH*BIN_W-1:0] tdc_vals,
   input logic [BIN_W-1:0]      cur_bin
);
   localparam logic [BIN_W-1:0] TOP = '1;
   localparam logic [BIN_W-1:0] ONE = BIN_W'(1);

   // R6
   mark_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cross_mark |=> data_valid);

   // R6
   no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cross_mark |=> !data_valid);

   // R6
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> ($stable(trig_word) && $stable(tdc_vals) && $stable(tdc_valid)));

   // R7
   trig_equals_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_word == tdc_valid);

   // R2
   bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cross_mark && $past(rst_n) && ($past(cur_bin) != TOP)) |->
         (cur_bin == $past(cur_bin) + ONE));

   // R3
   bin_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cross_mark && $past(rst_n) && ($past(cur_bin) == TOP)) |-> (cur_bin == TOP));

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
      // R7
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tdc_valid[ch] |-> (tdc_vals[BIN_W*ch +: BIN_W] == '0));
   end
endmodule

bind beam_tdc beam_tdc_chk #(.N_CH(N_CH), .BIN_W(BIN_W)) i_beam_tdc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cross_mark (cross_mark),
   .data_valid (data_valid),
   .trig_word  (trig_word),
   .tdc_valid  (tdc_valid),
   .tdc_vals   (tdc_vals),
   .cur_bin    (cur_bin)
);

// File: tb/test_beam_tdc.sv
module test_beam_tdc;
   localparam int N   = 32;
   localparam int BW  = 6;
   localparam logic [BW-1:0] TOPV = '1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cross_mark = 1'b0;
   logic [N-1:0]    disc_in = '0;
   logic            data_valid;
   logic [N-1:0]    trig_word;
   logic [N-1:0]    tdc_valid;
   logic [N*BW-1:0] tdc_vals;

   int n_checks = 0;
   int n_fails  = 0;

   beam_tdc i_beam_tdc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cross_mark (cross_mark),
      .disc_in    (disc_in),
      .data_valid (data_valid),
      .trig_word  (trig_word),
      .tdc_valid  (tdc_valid),
      .tdc_vals   (tdc_vals)
   );

   always #10 clk = ~clk;

   // expected-behaviour state, advanced once per fast cycle
   logic [N-1:0]  m_d1 = '0, m_d2 = '0, m_d3 = '0;
   logic [N-1:0]  m_hit = '0, m_ohit = '0;
   logic [BW-1:0] m_val  [N];
   logic [BW-1:0] m_oval [N];
   logic [BW-1:0] m_bin = '0;
   logic          m_dv = 1'b0;

   function automatic logic [N*BW-1:0] pack_exp();
      logic [N*BW-1:0] v = '0;
      for (int c = 0; c < N; c++) v[BW*c +: BW] = m_oval[c];
      return v;
   endfunction

   function automatic logic [BW-1:0] field(input logic [N*BW-1:0] v, input int c);
      return v[BW*c +: BW];
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [N*BW-1:0] act,
                      input logic [N*BW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_model();
      chk(data_valid == m_dv, "R6 strobe", N*BW'(data_valid), N*BW'(m_dv));
      chk(trig_word == m_ohit, "R7 trigger word", N*BW'(trig_word), N*BW'(m_ohit));
      chk(tdc_valid == m_ohit, "R7 valid bits", N*BW'(tdc_valid), N*BW'(m_ohit));
      chk(tdc_vals == pack_exp(), "R4 R9 time values", tdc_vals, pack_exp());
   endtask

   task automatic model_step(input logic mark, input logic [N-1:0] disc);
      logic [N-1:0]  rise = m_d2 & ~m_d3;
      logic [BW-1:0] eb = mark ? '0 : m_bin;
      for (int c = 0; c < N; c++) begin
         if (mark) begin
            m_ohit[c] = m_hit[c];
            m_oval[c] = m_val[c];
            m_hit[c]  = rise[c];
            m_val[c]  = rise[c] ? eb : '0;
         end else if (rise[c] && !m_hit[c]) begin
            m_hit[c] = 1'b1;
            m_val[c] = eb;
         end
      end
      m_dv  = mark;
      m_bin = mark ? BW'(1) : ((m_bin == TOPV) ? TOPV : m_bin + BW'(1));
      m_d3 = m_d2;
      m_d2 = m_d1;
      m_d1 = disc;
   endtask

   // one fast cycle: check last results, drive inputs away from the edge
   task automatic cycle(input logic mark, input logic [N-1:0] disc);
      @(negedge clk);
      compare_model();
      cross_mark = mark;
      disc_in    = disc;
      model_step(mark, disc);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [N-1:0] d;
      void'($urandom(32'd4242));
      for (int c = 0; c < N; c++) begin
         m_val[c] = '0;
         m_oval[c] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(data_valid == 1'b0, "R1 strobe in reset", N*BW'(data_valid), '0);
      chk(trig_word == '0, "R1 trigger in reset", N*BW'(trig_word), '0);
      chk(tdc_valid == '0, "R1 valid in reset", N*BW'(tdc_valid), '0);
      chk(tdc_vals == '0, "R1 values in reset", tdc_vals, '0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) cycle(1'b0, '0);
      chk(trig_word == '0 && tdc_vals == '0, "R1 idle after reset", tdc_vals, '0);

      // directed: crossings start at cycles 0, 20, 100
      for (int cyc = 0; cyc < 120; cyc++) begin
         d = '0;
         d[0] = (cyc >= 3);
         d[1] = (cyc >= 18);
         d[2] = (cyc >= 5 && cyc < 7) || (cyc >= 10);
         d[3] = (cyc >= 88);
         cycle(cyc == 0 || cyc == 20 || cyc == 100, d);
         if (cyc == 21) begin
            chk(trig_word == 32'h5, "R7 trigger word first crossing", N*BW'(trig_word), N*BW'(32'h5));
            chk(field(tdc_vals, 0) == 6'd5, "R4 ch0 time", N*BW'(field(tdc_vals, 0)), N*BW'(5));
            chk(field(tdc_vals, 2) == 6'd7, "R5 ch2 first edge only", N*BW'(field(tdc_vals, 2)), N*BW'(7));
            chk(!tdc_valid[1] && field(tdc_vals, 1) == '0, "R8 boundary edge not in old crossing",
                N*BW'(field(tdc_vals, 1)), '0);
            chk(data_valid == 1'b1, "R6 strobe after mark", N*BW'(data_valid), N*BW'(1));
         end
         if (cyc == 22)
            chk(data_valid == 1'b0, "R6 strobe one cycle", N*BW'(data_valid), '0);
         if (cyc == 101) begin
            chk(trig_word == 32'hA, "R7 trigger word long crossing", N*BW'(trig_word), N*BW'(32'hA));
            chk(tdc_valid[1] && field(tdc_vals, 1) == '0, "R8 boundary edge value zero",
                N*BW'(field(tdc_vals, 1)), '0);
            chk(field(tdc_vals, 3) == TOPV, "R3 saturated time", N*BW'(field(tdc_vals, 3)), N*BW'(TOPV));
            chk(!tdc_valid[0] && field(tdc_vals, 0) == '0, "R7 no hit reports zero",
                N*BW'(field(tdc_vals, 0)), '0);
            chk(tdc_vals[BW*3 +: BW] == 6'h3F, "R9 channel 3 field position",
                N*BW'(tdc_vals[BW*3 +: BW]), N*BW'(6'h3F));
         end
      end

      // constrained random crossings of varied length
      d = '0;
      for (int x = 0; x < 60; x++) begin
         int len = 4 + int'($urandom % 90);
         for (int k = 0; k < len; k++) begin
            d = d ^ ($urandom & $urandom & $urandom);
            cycle(k == 0, d);
         end
      end
      cycle(1'b1, d);
      cycle(1'b0, d);
      cycle(1'b0, d);
      summary();
      $finish;
   end
endmodule